// File: doc/BRIEF.md
# Relative Jump Target Unit

This block sits in the fetch stage of a small processor core. Each cycle it receives one 16-bit instruction word, the program counter of that word, and a strobe that marks the word as valid. It recognises two instruction forms that change the program flow by a signed distance: a relative jump and a relative call. Both forms carry a 12-bit two's-complement word offset in their low bits. For either form the block raises a taken flag and computes the new program counter. For a call it also raises a call flag, so that the stack logic outside the block can push the return address.

Both forms share one adder path. The target is the address of the following word plus the sign-extended offset, so an offset of minus one loops back onto the instruction itself. All arithmetic wraps modulo 2^16. When no flow change is decoded, the target output carries the sequential address, and the fetch logic can use it unchanged. All outputs are registered and appear one cycle after the inputs are sampled.

Top module: `rjt_unit`

## Requirements
- R1: While rst is high at a rising edge, taken_o, call_o, target_o and ret_addr_o are all cleared to zero at that edge.
- R2: When valid_i is high and instr_i[15:12] equals 4'b1100 (jump), taken_o is 1 and call_o is 0, and target_o is (pc_i + 1 + sign-extended instr_i[11:0]) mod 2^16.
- R3: When valid_i is high and instr_i[15:12] equals 4'b1101 (call), taken_o and call_o are both 1, and target_o is computed exactly as for a jump.
- R4: ret_addr_o is (pc_i + 1) mod 2^16 for every sampled input, whatever the instruction.
- R5: When valid_i is low, taken_o and call_o are 0 and target_o equals (pc_i + 1) mod 2^16, whatever instr_i holds.
- R6: When valid_i is high and instr_i[15:12] is any value other than 4'b1100 or 4'b1101, taken_o and call_o are 0 and target_o equals (pc_i + 1) mod 2^16.
- R7: The offset field instr_i[11:0] is two's complement with bit 11 as the sign. An offset of 12'hFFF (-1) gives target_o equal to pc_i, so the instruction jumps to itself.
- R8: An offset of 12'h800 moves the target by -2048 from pc_i + 1, and 12'h7FF moves it by +2047. Word 16'hC006 at pc_i gives target pc_i + 7.
- R9: The target wraps modulo 2^16 at both ends of the address space.
- R10: Every output reflects the inputs sampled at the previous rising edge of clk (one cycle of latency).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Instruction word valid strobe |
| instr_i | input | 16 | Instruction word |
| pc_i | input | 16 | Program counter of the instruction word |
| taken_o | output | 1 | A relative jump or call was decoded |
| call_o | output | 1 | The decoded flow change is a call |
| target_o | output | 16 | Next program counter |
| ret_addr_o | output | 16 | Return address, pc_i + 1 |

## Verification
Directed words cover each corner separately. The word 0xC006 checks the positive-offset path. Offsets 0xFFF, 0x800 and 0x7FF check sign extension: a wrong sign bit or a missing +1 moves these targets by a visible amount. Counter values near 0x0000 and 0xFFFF show whether the sum wraps. Call words check that the call flag is separated from the jump flag. Valid-low cycles and foreign prefixes such as 0xE and 0x4 check that nothing outside the two prefixes is decoded. Random words drawn from all sixteen prefixes, with the strobe toggled, then check prefix matching and the shared adder across the whole offset and counter range.

// File: rtl/rjt_pkg.sv
package rjt_pkg;

    parameter int PC_W  = 16;
    parameter int OPC_W = 4;
    parameter int OFS_W = 12;

    localparam logic [OPC_W-1:0] PFX_JUMP = 4'b1100;
    localparam logic [OPC_W-1:0] PFX_CALL = 4'b1101;

    typedef enum logic [1:0] {
        FLOW_SEQ  = 2'd0,
        FLOW_JUMP = 2'd1,
        FLOW_CALL = 2'd2
    } flow_e;

    typedef struct packed {
        logic            taken;
        logic            call;
        logic [PC_W-1:0] target;
        logic [PC_W-1:0] ret_addr;
    } flow_res_t;

    function automatic logic [PC_W-1:0] sext_ofs(input logic [OFS_W-1:0] k);
        return {{(PC_W-OFS_W){k[OFS_W-1]}}, k};
    endfunction

endpackage

// File: rtl/rjt_decode.sv
module rjt_decode
    import rjt_pkg::*;
(
    input  logic             valid_i,
    input  logic [PC_W-1:0]  instr_i,
    output flow_e            kind_o,
    output logic [OFS_W-1:0] ofs_o
);
    localparam int TOP = PC_W - 1;

    logic [OPC_W-1:0] prefix;
    assign prefix = instr_i[TOP -: OPC_W];
    assign ofs_o  = instr_i[OFS_W-1:0];

    always_comb begin
        kind_o = FLOW_SEQ;
        if (valid_i) begin
            if (prefix == PFX_JUMP)      kind_o = FLOW_JUMP;
            else if (prefix == PFX_CALL) kind_o = FLOW_CALL;
        end
    end
endmodule

// File: rtl/rjt_target.sv
module rjt_target
    import rjt_pkg::*;
(
    input  flow_e            kind_i,
    input  logic [OFS_W-1:0] ofs_i,
    input  logic [PC_W-1:0]  pc_i,
    output flow_res_t        res_o
);
    logic [PC_W-1:0] seq_addr;
    logic [PC_W-1:0] addend;

    assign seq_addr = pc_i + PC_W'(1);
    assign addend   = (kind_i == FLOW_SEQ) ? '0 : sext_ofs(ofs_i);

    always_comb begin
        res_o.taken    = (kind_i != FLOW_SEQ);
        res_o.call     = (kind_i == FLOW_CALL);
        res_o.target   = seq_addr + addend;
        res_o.ret_addr = seq_addr;
    end
endmodule

// File: rtl/rjt_unit.sv
module rjt_unit
    import rjt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        valid_i,
    input  logic [15:0] instr_i,
    input  logic [15:0] pc_i,
    output logic        taken_o,
    output logic        call_o,
    output logic [15:0] target_o,
    output logic [15:0] ret_addr_o
);
    flow_e            kind;
    logic [OFS_W-1:0] ofs;
    flow_res_t        res_d;
    flow_res_t        res_q;

    rjt_decode u_decode (
        .valid_i (valid_i),
        .instr_i (instr_i),
        .kind_o  (kind),
        .ofs_o   (ofs)
    );

    rjt_target u_target (
        .kind_i (kind),
        .ofs_i  (ofs),
        .pc_i   (pc_i),
        .res_o  (res_d)
    );

    // R10: single output register stage
    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign taken_o    = res_q.taken;
    assign call_o     = res_q.call;
    assign target_o   = res_q.target;
    assign ret_addr_o = res_q.ret_addr;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (!taken_o && !call_o && target_o == '0 && ret_addr_o == '0));

    // R3
    call_implies_taken_chk: assert property (@(posedge clk) disable iff (rst)
        call_o |-> taken_o);

    // R4
    ret_addr_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (ret_addr_o == $past(pc_i) + 16'd1));

    // R5
    idle_seq_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(valid_i)) |-> (!taken_o && !call_o && target_o == ret_addr_o));

    // R6
    prefix_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && taken_o) |-> ($past(valid_i) && $past(instr_i[15:13]) == 3'b110));

    // R2
    offset_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && taken_o) |->
            (target_o - ret_addr_o == {{4{$past(instr_i[11])}}, $past(instr_i[11:0])}));
endmodule

// File: tb/rjt_unit_bench.sv
module rjt_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [15:0] instr_i = '0;
    logic [15:0] pc_i = '0;
    logic        taken_o, call_o;
    logic [15:0] target_o, ret_addr_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    rjt_unit u_rjt_unit (
        .clk        (clk),
        .rst        (rst),
        .valid_i    (valid_i),
        .instr_i    (instr_i),
        .pc_i       (pc_i),
        .taken_o    (taken_o),
        .call_o     (call_o),
        .target_o   (target_o),
        .ret_addr_o (ret_addr_o)
    );

    function automatic logic [15:0] exp_target(input logic v, input logic [15:0] w, input logic [15:0] pc);
        logic [15:0] nxt = pc + 16'd1;
        if (v && (w[15:12] == 4'hC || w[15:12] == 4'hD))
            return nxt + {{4{w[11]}}, w[11:0]};
        return nxt;
    endfunction

    task automatic check(input string req, input logic [50:0] act, input logic [50:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive at negedge, result registered at next posedge, sample at the following negedge
    task automatic apply(input string req, input logic v, input logic [15:0] w, input logic [15:0] pc);
        logic et, ec;
        valid_i = v; instr_i = w; pc_i = pc;
        @(negedge clk);
        et = v && (w[15:12] == 4'hC || w[15:12] == 4'hD);
        ec = v && (w[15:12] == 4'hD);
        check(req, {taken_o, call_o, target_o, ret_addr_o, 1'b0},
                   {et, ec, exp_target(v, w, pc), pc + 16'd1, 1'b0});
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed = 32'd1234;
        void'($urandom(seed));
        repeat (2) @(negedge clk);
        // R1 reset state
        check("R1", {taken_o, call_o, target_o, ret_addr_o, 1'b0}, '0);
        rst = 1'b0;
        apply("R8 C006 forward +6", 1'b1, 16'hC006, 16'h0100);
        check("R8 C006 target", {35'd0, target_o}, {35'd0, 16'h0107});
        apply("R2 jump", 1'b1, 16'hC123, 16'h2000);
        apply("R7 self loop", 1'b1, 16'hCFFF, 16'h1234);
        check("R7 self loop target", {35'd0, target_o}, {35'd0, 16'h1234});
        apply("R8 min offset", 1'b1, 16'hC800, 16'h4000);
        check("R8 min target", {35'd0, target_o}, {35'd0, 16'h3801});
        apply("R8 max offset", 1'b1, 16'hC7FF, 16'h4000);
        check("R8 max target", {35'd0, target_o}, {35'd0, 16'h4800});
        apply("R3 call", 1'b1, 16'hD010, 16'h0050);
        apply("R3 call back", 1'b1, 16'hDFF0, 16'h0050);
        apply("R4 ret on call", 1'b1, 16'hD001, 16'hABCD);
        check("R4 ret value", {35'd0, ret_addr_o}, {35'd0, 16'hABCE});
        apply("R9 wrap up", 1'b1, 16'hC000, 16'hFFFF);
        check("R9 wrap to zero", {35'd0, target_o}, '0);
        apply("R9 wrap down", 1'b1, 16'hC800, 16'h0010);
        apply("R5 valid low jump", 1'b0, 16'hC006, 16'h0300);
        apply("R5 valid low call", 1'b0, 16'hD7FF, 16'h0300);
        apply("R6 prefix E", 1'b1, 16'hE123, 16'h0400);
        apply("R6 prefix 4", 1'b1, 16'h4FFF, 16'h0400);
        apply("R6 prefix F", 1'b1, 16'hF800, 16'h0400);
        // R10 back-to-back words: each result follows its own input
        for (int i = 0; i < 400; i++) begin
            logic [15:0] w = 16'($urandom);
            logic [15:0] pc = 16'($urandom);
            logic v = ($urandom % 4) != 0;
            if (($urandom % 3) == 0) w[15:12] = 4'hC + 4'($urandom % 2);
            apply("R10 random", v, w, pc);
        end
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset again", {taken_o, call_o, target_o, ret_addr_o, 1'b0}, '0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule